// File: doc/BRIEF.md
# Stochastic Number Generator Bank

This block turns binary numbers into stochastic bitstreams. Every lane holds a WIDTH-bit value and, on each enabled clock, compares it with a random or quasi-random number. The registered lane output is 1 when that number is below the value, so over a full sequence period the fraction of ones equals value / 2^WIDTH.

Random numbers come from a set of source groups. Each group holds three generators: a maximal-length shift register, a bit-reversed binary counter (base-2 Van der Corput), and a digit-reversed ternary counter scaled to the binary range (base-3 Halton). A lane selects a group and a generator kind. Lanes that share a group and kind see the same number every cycle, so their streams are positively correlated. Lanes on different groups see independent sequences. To offer the same operand with both relationships to a partner stream, feed one value to two lanes: one in the partner's group and one in another group.

One enable advances all generators and all lane outputs. A sync pulse reloads every generator from its group's seed.

Top module: `sng_bank`

## Requirements
- R1: While rst_n is low and in the first cycle after it, stream is all zeros. The generators then start from their reset states: shift register 1, binary counter 0, ternary counter 0.
- R2: On a clock edge with en=1 and sync=0, each lane's stream bit becomes 1 exactly when its selected source value, as it was before the edge, is below its value input (unsigned). A value of 0 always gives 0, and a value of 2^WIDTH-1 gives 1 except when the source equals 2^WIDTH-1.
- R3: The shift-register source shifts left and takes into bit 0 the XOR of the state bits selected by the tap mask (0xB8 for WIDTH=8). It never holds zero, and its period is 2^WIDTH-1, so a value v≥1 gives v-1 ones per period.
- R4: The binary-counter source increments modulo 2^WIDTH, and its output is the counter with its bits reversed. Any 2^WIDTH consecutive enabled cycles give exactly value ones.
- R5: The ternary source is a DIGITS-digit base-3 counter (DIGITS=6 for WIDTH=8) that wraps at 3^DIGITS. The digits are reversed into an integer h, and the output is (h × floor(2^(2·WIDTH+8) / 3^DIGITS)) >> (WIDTH+8). For WIDTH=8 this is (h × 23014) >> 16.
- R6: On an edge with en=0 and sync=0, no generator advances and every stream bit keeps its value.
- R7: On an edge with sync=1, whatever en is, every generator loads its group's seed and stream keeps its value. The shift register loads 1 when the seed is 0. The ternary counter loads the seed's value.
- R8: The lane kind code is 0 for shift register, 1 for binary counter, 2 for ternary, and 3 for off. Off drives the lane's stream to 0 on enabled edges.
- R9: A lane uses the sources of the group named by its group field. Two lanes with equal group, kind and value produce identical streams. Lanes on different groups follow their own groups' sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance generators and update streams |
| sync | input | 1 | Reload all generators from seeds |
| seed | input | GROUPS*WIDTH | Per-group seed, group g at bits [g*WIDTH +: WIDTH] |
| value | input | LANES*WIDTH | Per-lane binary value |
| kind | input | LANES*2 | Per-lane source kind code |
| group | input | LANES*GW | Per-lane group index |
| stream | output | LANES | Per-lane stochastic bit |

## Verification
Every lane result is due on the first clock edge after the inputs that produce it. That result is built from the source state before that edge. A sync edge or a disabled edge keeps the previous bit. The driver sets inputs one nanosecond after a rising edge and computes the expected vector from its own generator models. It queues that vector at the capturing edge, and the monitor compares it at the following falling edge. The density checks over a full period are made only after the queue has drained.

// File: rtl/sng_pkg.sv
`timescale 1ns/1ps
package sng_pkg;

    typedef enum logic [1:0] {
        SRC_LFSR   = 2'd0,
        SRC_VDC    = 2'd1,
        SRC_HALTON = 2'd2,
        SRC_OFF    = 2'd3
    } src_kind_e;

    // Maximal-length feedback masks, bit (t-1) set for each tap t.
    function automatic logic [31:0] lfsr_taps(input int w);
        case (w)
            3:       return 32'h0000_0006;
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            12:      return 32'h0000_0829;
            13:      return 32'h0000_100D;
            14:      return 32'h0000_2015;
            15:      return 32'h0000_6000;
            16:      return 32'h0000_D008;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Smallest digit count whose ternary span covers 2^w.
    function automatic int tern_digits(input int w);
        int     d;
        longint p;
        d = 0;
        p = 1;
        while (p < (longint'(1) << w)) begin
            p = p * 3;
            d++;
        end
        return d;
    endfunction

    function automatic longint pow3(input int n);
        longint p;
        p = 1;
        for (int i = 0; i < n; i++) p = p * 3;
        return p;
    endfunction

endpackage

// File: rtl/sng_lfsr.sv
`timescale 1ns/1ps
module sng_lfsr
    import sng_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] rnd
);
    localparam logic [WIDTH-1:0] TAPS = WIDTH'(lfsr_taps(WIDTH));

    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync) begin
            st_d.sr = (seed == '0) ? WIDTH'(1) : seed;
        end else if (en) begin
            st_d.sr = {st_q.sr[WIDTH-2:0], ^(st_q.sr & TAPS)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sr: WIDTH'(1)};
        else        st_q <= st_d;
    end

    assign rnd = st_q.sr;

    p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0)
        else $error("shift register reached zero");

    p_lfsr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sync) |=> $stable(rnd))
        else $error("shift register moved while idle");

    p_lfsr_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && seed != '0) |=> (rnd == $past(seed)))
        else $error("shift register did not load seed");

endmodule

// File: rtl/sng_vdc.sv
`timescale 1ns/1ps
module sng_vdc #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] rnd
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } vdc_st_t;

    vdc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync)    st_d.cnt = seed;
        else if (en) st_d.cnt = st_q.cnt + WIDTH'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) rnd[i] = st_q.cnt[WIDTH-1-i];
    end

    p_vdc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sync) |=> (st_q.cnt == WIDTH'($past(st_q.cnt) + WIDTH'(1))))
        else $error("binary counter did not step");

    p_vdc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sync) |=> $stable(rnd))
        else $error("binary counter moved while idle");

endmodule

// File: rtl/sng_halton.sv
`timescale 1ns/1ps
module sng_halton
    import sng_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] rnd
);
    localparam int     DIGITS = tern_digits(WIDTH);
    localparam longint SPAN   = pow3(DIGITS);
    localparam int     SHIFT  = WIDTH + 8;
    localparam longint SCALE  = (longint'(1) << (WIDTH + SHIFT)) / SPAN;
    localparam int     HW     = $clog2(SPAN);
    localparam int     PW     = WIDTH + SHIFT + 1;

    typedef struct packed {
        logic [DIGITS-1:0][1:0] dig;
    } hal_st_t;

    hal_st_t          st_d, st_q;
    logic             carry;
    logic [HW-1:0]    rev;
    logic [PW-1:0]    prod;

    function automatic logic [DIGITS-1:0][1:0] to_digits(input logic [WIDTH-1:0] v);
        logic [DIGITS-1:0][1:0] d;
        logic [WIDTH-1:0]       r;
        r = v;
        for (int i = 0; i < DIGITS; i++) begin
            d[i] = 2'(r % WIDTH'(3));
            r    = r / WIDTH'(3);
        end
        return d;
    endfunction

    always_comb begin
        st_d  = st_q;
        carry = 1'b1;
        if (sync) begin
            st_d.dig = to_digits(seed);
        end else if (en) begin
            for (int i = 0; i < DIGITS; i++) begin
                if (carry) begin
                    if (st_q.dig[i] == 2'd2) begin
                        st_d.dig[i] = 2'd0;
                    end else begin
                        st_d.dig[i] = st_q.dig[i] + 2'd1;
                        carry       = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Least significant counter digit carries the heaviest weight.
    always_comb begin
        rev = '0;
        for (int i = 0; i < DIGITS; i++) begin
            rev = rev + (HW'(st_q.dig[i]) * HW'(pow3(DIGITS - 1 - i)));
        end
        prod = PW'(rev) * PW'(SCALE);
        rnd  = prod[SHIFT +: WIDTH];
    end

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit_chk
        p_digit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.dig[i] != 2'd3)
            else $error("ternary digit out of range");
    end

    p_hal_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sync) |=> $stable(rnd))
        else $error("ternary counter moved while idle");

endmodule

// File: rtl/sng_lane.sv
`timescale 1ns/1ps
module sng_lane
    import sng_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int GROUPS = 2,
    parameter int GW     = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          sync,
    input  logic [WIDTH-1:0]              value,
    input  logic [1:0]                    kind,
    input  logic [GW-1:0]                 grp,
    input  logic [GROUPS-1:0][WIDTH-1:0]  lfsr_rnd,
    input  logic [GROUPS-1:0][WIDTH-1:0]  vdc_rnd,
    input  logic [GROUPS-1:0][WIDTH-1:0]  hal_rnd,
    output logic                          bit_o
);
    typedef struct packed {
        logic bit_v;
    } lane_st_t;

    lane_st_t         st_d, st_q;
    logic [GW-1:0]    gi;
    logic [WIDTH-1:0] pick;

    always_comb begin
        gi = grp;
        if (32'(grp) >= GROUPS) gi = '0;
        case (src_kind_e'(kind))
            SRC_LFSR:   pick = lfsr_rnd[gi];
            SRC_VDC:    pick = vdc_rnd[gi];
            SRC_HALTON: pick = hal_rnd[gi];
            default:    pick = '0;
        endcase
        st_d = st_q;
        if (en && !sync) begin
            st_d.bit_v = (src_kind_e'(kind) != SRC_OFF) && (pick < value);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.bit_v;

    p_zero_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sync && value == '0) |=> !bit_o)
        else $error("zero value produced a one");

    p_off_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sync && kind == 2'd3) |=> !bit_o)
        else $error("off lane produced a one");

    p_lane_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || sync) |=> $stable(bit_o))
        else $error("lane output changed without update");

endmodule

// File: rtl/sng_bank.sv
`timescale 1ns/1ps
module sng_bank
    import sng_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int GROUPS = 2,
    parameter int WIDTH  = 8,
    parameter int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      sync,
    input  logic [GROUPS*WIDTH-1:0]   seed,
    input  logic [LANES*WIDTH-1:0]    value,
    input  logic [LANES*2-1:0]        kind,
    input  logic [LANES*GW-1:0]       group,
    output logic [LANES-1:0]          stream
);
    logic [GROUPS-1:0][WIDTH-1:0] lfsr_rnd;
    logic [GROUPS-1:0][WIDTH-1:0] vdc_rnd;
    logic [GROUPS-1:0][WIDTH-1:0] hal_rnd;

    for (genvar g = 0; g < GROUPS; g++) begin : g_src
        sng_lfsr #(.WIDTH(WIDTH)) u_lfsr (
            .clk(clk), .rst_n(rst_n), .en(en), .sync(sync),
            .seed(seed[g*WIDTH +: WIDTH]), .rnd(lfsr_rnd[g])
        );
        sng_vdc #(.WIDTH(WIDTH)) u_vdc (
            .clk(clk), .rst_n(rst_n), .en(en), .sync(sync),
            .seed(seed[g*WIDTH +: WIDTH]), .rnd(vdc_rnd[g])
        );
        sng_halton #(.WIDTH(WIDTH)) u_hal (
            .clk(clk), .rst_n(rst_n), .en(en), .sync(sync),
            .seed(seed[g*WIDTH +: WIDTH]), .rnd(hal_rnd[g])
        );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sng_lane #(.WIDTH(WIDTH), .GROUPS(GROUPS), .GW(GW)) u_lane (
            .clk(clk), .rst_n(rst_n), .en(en), .sync(sync),
            .value(value[l*WIDTH +: WIDTH]),
            .kind(kind[l*2 +: 2]),
            .grp(group[l*GW +: GW]),
            .lfsr_rnd(lfsr_rnd), .vdc_rnd(vdc_rnd), .hal_rnd(hal_rnd),
            .bit_o(stream[l])
        );
    end

    for (genvar i = 0; i < LANES; i++) begin : g_pair_i
        for (genvar j = i + 1; j < LANES; j++) begin : g_pair_j
            p_same_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (en && !sync
                 && kind[i*2 +: 2] == kind[j*2 +: 2]
                 && group[i*GW +: GW] == group[j*GW +: GW]
                 && value[i*WIDTH +: WIDTH] == value[j*WIDTH +: WIDTH])
                |=> (stream[i] == stream[j]))
                else $error("lanes sharing a source diverged");
        end
    end

endmodule

// File: tb/sng_bank_tb.sv
`timescale 1ns/1ps
module sng_bank_tb;
    localparam int W  = 8;
    localparam int G  = 2;
    localparam int L  = 4;
    localparam int GW = 1;
    localparam longint HK = (longint'(1) << 24) / 729;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b0;
    logic           sync = 1'b0;
    logic [G*W-1:0] seed = '0;
    logic [L*W-1:0] value = '0;
    logic [2*L-1:0] kind = '0;
    logic [L*GW-1:0] group = '0;
    logic [L-1:0]   stream;

    always #2 clk = ~clk;

    sng_bank #(.LANES(L), .GROUPS(G), .WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .sync(sync), .seed(seed),
        .value(value), .kind(kind), .group(group), .stream(stream)
    );

    typedef struct {
        logic [L-1:0] bits;
        string        tag;
        bit           cnt;
    } item_t;

    item_t      q[$];
    int         checks = 0;
    int         fails = 0;
    int         ones[L];
    string      cur_tag = "R1";
    bit         counting = 1'b0;
    logic [7:0] m_lfsr[G];
    logic [7:0] m_vdc[G];
    int         m_hn[G];
    logic [L-1:0] exp_bits = '0;

    function automatic logic [7:0] hal_val(input int n);
        int rev, v;
        rev = 0;
        v = n;
        for (int i = 0; i < 6; i++) begin
            rev = rev * 3 + v % 3;
            v = v / 3;
        end
        return 8'((longint'(rev) * HK) >> 16);
    endfunction

    function automatic logic [7:0] src_val(input int k, input int g);
        logic [7:0] r;
        case (k)
            0: r = m_lfsr[g];
            1: for (int i = 0; i < 8; i++) r[i] = m_vdc[g][7-i];
            2: r = hal_val(m_hn[g]);
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    task automatic set_lane(input int l, input int k, input int g, input int v);
        kind[2*l +: 2]     = 2'(k);
        group[l]           = 1'(g);
        value[l*W +: W]    = 8'(v);
    endtask

    task automatic step(input bit e, input bit s);
        item_t it;
        if (e && !s) begin
            for (int l = 0; l < L; l++) begin
                int k, g;
                k = int'(kind[2*l +: 2]);
                g = int'(group[l]);
                exp_bits[l] = (k != 3) && (src_val(k, g) < value[l*W +: W]);
            end
        end
        en = e;
        sync = s;
        @(posedge clk);
        it.bits = exp_bits;
        it.tag = cur_tag;
        it.cnt = counting;
        q.push_back(it);
        for (int g = 0; g < G; g++) begin
            if (s) begin
                logic [7:0] sd;
                sd = seed[g*W +: W];
                m_lfsr[g] = (sd == 8'h00) ? 8'h01 : sd;
                m_vdc[g] = sd;
                m_hn[g] = int'(sd);
            end else if (e) begin
                m_lfsr[g] = {m_lfsr[g][6:0], ^(m_lfsr[g] & 8'hB8)};
                m_vdc[g] = m_vdc[g] + 8'd1;
                m_hn[g] = (m_hn[g] + 1) % 729;
            end
        end
        #1;
    endtask

    task automatic drain();
        step(1'b0, 1'b0);
        @(negedge clk);
        #1;
        @(posedge clk);
        #1;
    endtask

    task automatic check_int(input string tag, input int got, input int expv);
        checks++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    always @(negedge clk) begin
        item_t it;
        if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (stream !== it.bits) begin
                fails++;
                $display("FAIL %s: stream=%b expected %b", it.tag, stream, it.bits);
            end
            if (it.cnt) for (int l = 0; l < L; l++) ones[l] += int'(stream[l]);
        end
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run not finished, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int hal_exp;
        for (int g = 0; g < G; g++) begin
            m_lfsr[g] = 8'h01;
            m_vdc[g] = 8'h00;
            m_hn[g] = 0;
        end
        for (int l = 0; l < L; l++) ones[l] = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 stream after reset", int'(stream), 0);
        @(posedge clk);
        #1;

        // Sources from reset state, all kinds plus an off lane (R1 R3 R4 R5 R8)
        cur_tag = "R1 R3 R4 R5 R8 reset-state sequences";
        set_lane(0, 0, 0, 8'h80);
        set_lane(1, 1, 0, 8'h40);
        set_lane(2, 2, 1, 8'hC0);
        set_lane(3, 3, 1, 8'hFF);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0);

        // Seed load, zero seed on group 1 (R7)
        cur_tag = "R7 seed load";
        seed = {8'h00, 8'h5A};
        step(1'b0, 1'b1);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0);

        // Idle cycles hold sources and streams (R6)
        cur_tag = "R6 hold while disabled";
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0);

        // Shared source lanes (R9)
        cur_tag = "R9 shared and separate groups";
        set_lane(0, 0, 0, 8'h20);
        set_lane(1, 0, 0, 8'h60);
        set_lane(2, 0, 1, 8'h60);
        set_lane(3, 0, 0, 8'h60);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);

        // Value extremes (R2)
        cur_tag = "R2 value extremes";
        set_lane(0, 1, 0, 8'h00);
        set_lane(1, 0, 1, 8'hFF);
        set_lane(2, 2, 1, 8'h00);
        set_lane(3, 2, 0, 8'hFF);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);

        // Sync has priority over enable, regrouped lanes (R7 R9)
        cur_tag = "R7 R9 sync with enable";
        seed = {8'h11, 8'hC3};
        set_lane(0, 0, 1, 8'h90);
        set_lane(1, 2, 0, 8'h50);
        set_lane(2, 1, 1, 8'hA0);
        set_lane(3, 0, 0, 8'h90);
        step(1'b1, 1'b1);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
        drain();

        // Binary counter density over 256 cycles (R4)
        cur_tag = "R4 density window";
        set_lane(0, 1, 0, 8'h37);
        set_lane(1, 1, 1, 8'h37);
        set_lane(2, 0, 0, 8'h37);
        set_lane(3, 2, 1, 8'h37);
        for (int l = 0; l < L; l++) ones[l] = 0;
        counting = 1'b1;
        for (int i = 0; i < 256; i++) step(1'b1, 1'b0);
        counting = 1'b0;
        drain();
        check_int("R4 ones in 256 cycles lane0", ones[0], 8'h37);
        check_int("R4 ones in 256 cycles lane1", ones[1], 8'h37);

        // Shift register density over one period (R3)
        cur_tag = "R3 density window";
        for (int l = 0; l < L; l++) ones[l] = 0;
        counting = 1'b1;
        for (int i = 0; i < 255; i++) step(1'b1, 1'b0);
        counting = 1'b0;
        drain();
        check_int("R3 ones in 255 cycles lane2", ones[2], 8'h37 - 1);

        // Ternary density over one period (R5)
        cur_tag = "R5 density window";
        hal_exp = 0;
        for (int n = 0; n < 729; n++) if (hal_val(n) < 8'h37) hal_exp++;
        for (int l = 0; l < L; l++) ones[l] = 0;
        counting = 1'b1;
        for (int i = 0; i < 729; i++) step(1'b1, 1'b0);
        counting = 1'b0;
        drain();
        check_int("R5 ones in 729 cycles lane3", ones[3], hal_exp);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule